// File: doc/BRIEF.md
# PPS-Synchronized 64-bit Time Base

This block keeps the running time of a system as a 32-bit seconds count and a 32-bit tick count. The tick count advances on every clock. When it reaches a programmable ticks-per-second limit minus one, it returns to zero and the seconds count steps up by one. Software sets the time in two steps. It first stages a seconds value and a tick value through write-only strobes. Writing the tick value arms a pending load.

The armed load is applied in one of two ways, chosen by an immediate flag. It can be applied on the next clock. It can instead wait for a pulse-per-second (PPS) event. Two PPS inputs are available: an external connector input and a cable-shared input. Each input passes through a two-flop synchronizer. A flags word selects which input is used and which edge counts. The selected edge produces a one-clock `pps_pulse_o`. The current time is presented as one 64-bit word, with seconds in the upper half.

Top module: `pps_time_base`

## Requirements
- R1: While `rst_ni` is low and after it is released, `time_now_o` is 0, `pending_o` is 0 and `pps_pulse_o` is 0 until the first tick advances the time. The default rollover value is `RESET_TPS`. Both flags default to 0. The immediate flag defaults to 0.
- R2: Without a commit, each clock increments the tick half (`time_now_o[31:0]`). When the tick half is at or above TPS−1, it becomes 0 and the seconds half (`time_now_o[63:32]`) increments. TPS is the full `cfg_data_i` word captured on a `wr_tps_i` clock.
- R3: A `wr_secs_i` clock stages `cfg_data_i` as the seconds to load. It does not arm a load and does not change `time_now_o`.
- R4: A `wr_ticks_i` clock stages `cfg_data_i` as the ticks to load. `pending_o` is high from the next clock and stays high until a commit.
- R5: `wr_imm_i` captures `cfg_data_i[0]`; 1 means immediate. In immediate mode, the clock after the tick write loads `time_now_o` = {staged seconds, staged ticks} and clears `pending_o`.
- R6: In PPS mode (immediate flag 0), an armed load waits. It commits on the clock that follows the first selected `pps_pulse_o` cycle.
- R7: `wr_flags_i` captures `cfg_data_i[1:0]`. Bit 0 chooses the PPS edge: 1 is rising, 0 is falling. `pps_pulse_o` is high for exactly one clock. That clock is the cycle after the second clock edge that samples the new input level.
- R8: Flag bit 1 selects the PPS input: 0 is `pps_ext_i`, 1 is `pps_cable_i`. Edges on the input that is not selected neither pulse nor commit.
- R9: A commit that falls in the same cycle as a tick rollover wins. The loaded value appears, not the wrapped value.
- R10: A PPS pulse while nothing is pending leaves the time counting normally.
- R11: A tick write in the commit cycle loads the previously staged ticks. It leaves `pending_o` high with the new ticks staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_ext_i | input | 1 | PPS from the external connector, asynchronous |
| pps_cable_i | input | 1 | PPS from the shared cable, asynchronous |
| wr_secs_i | input | 1 | Stage seconds strobe |
| wr_ticks_i | input | 1 | Stage ticks and arm strobe |
| wr_flags_i | input | 1 | Write PPS edge/source flags |
| wr_imm_i | input | 1 | Write immediate flag |
| wr_tps_i | input | 1 | Write ticks-per-second |
| cfg_data_i | input | 32 | Data for the write strobes |
| time_now_o | output | 64 | {seconds, ticks} |
| pps_pulse_o | output | 1 | One-clock pulse on the selected PPS edge |
| pending_o | output | 1 | A load is armed and not yet committed |

## Verification
A wrong pending state shows at the ports in two ways. A load commits a cycle early or late, or it never lands, and `time_now_o` differs from the expected value on the first cycle after the intended commit. A fault in the synchronizer history or the edge selection moves `pps_pulse_o` by a cycle or creates a false pulse, and the bench sees this on that same cycle. A bad rollover compare shows within one TPS period as a tick value beyond TPS−1 or a missed seconds step. Because the reference model is compared on every clock, each of these is caught on the first cycle it becomes visible.

// File: rtl/time_base_pkg.sv
package time_base_pkg;
  localparam int unsigned NUM_PPS_SRC = 2;
  localparam int unsigned FLAG_EDGE_BIT = 0;
  localparam int unsigned FLAG_SRC_BIT  = 1;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } pps_edge_e;

  typedef enum logic {
    SRC_EXT   = 1'b0,
    SRC_CABLE = 1'b1
  } pps_src_e;
endpackage

// File: rtl/pps_edge_detect.sv
module pps_edge_detect #(
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pps_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               rise_i,
  output logic               pulse_o
);
  logic [NUM_SRC-1:0] pulse_vec;

  // each source keeps its own history so a source switch makes no false edge
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES:0] hist_q;
    logic                 cur, prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= {hist_q[SYNC_STAGES-1:0], pps_i[g]};
    end

    assign cur  = hist_q[SYNC_STAGES-1];
    assign prev = hist_q[SYNC_STAGES];
    assign pulse_vec[g] = rise_i ? (cur & ~prev) : (~cur & prev);
  end

  assign pulse_o = pulse_vec[sel_i];
endmodule

// File: rtl/time_load_stage.sv
module time_load_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_secs_i,
  input  logic              wr_ticks_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              imm_i,
  input  logic              pps_pulse_i,
  output logic [WORD_W-1:0] stage_secs_o,
  output logic [WORD_W-1:0] stage_ticks_o,
  output logic              pending_o,
  output logic              commit_o
);
  logic [WORD_W-1:0] secs_q, ticks_q;
  logic              pend_q;

  assign commit_o = pend_q & (imm_i | pps_pulse_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q  <= '0;
      ticks_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_secs_i) secs_q <= data_i;
      if (wr_ticks_i) begin
        ticks_q <= data_i;
        pend_q  <= 1'b1;   // re-arm wins over a same-cycle commit
      end else if (commit_o) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign stage_secs_o  = secs_q;
  assign stage_ticks_o = ticks_q;
  assign pending_o     = pend_q;
endmodule

// File: rtl/time_counter.sv
module time_counter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_secs_i,
  input  logic [WORD_W-1:0] load_ticks_i,
  input  logic [WORD_W-1:0] tps_i,
  output logic [WORD_W-1:0] secs_o,
  output logic [WORD_W-1:0] ticks_o
);
  logic [WORD_W-1:0] secs_q, ticks_q, last_tick;
  logic              wrap;

  assign last_tick = tps_i - 1'b1;
  assign wrap      = (ticks_q >= last_tick);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q  <= '0;
      ticks_q <= '0;
    end else if (load_i) begin
      secs_q  <= load_secs_i;
      ticks_q <= load_ticks_i;
    end else if (wrap) begin
      secs_q  <= secs_q + 1'b1;
      ticks_q <= '0;
    end else begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  assign secs_o  = secs_q;
  assign ticks_o = ticks_q;
endmodule

// File: rtl/pps_time_base.sv
module pps_time_base
  import time_base_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] RESET_TPS   = 32'd250_000_000,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_ext_i,
  input  logic              pps_cable_i,
  input  logic              wr_secs_i,
  input  logic              wr_ticks_i,
  input  logic              wr_flags_i,
  input  logic              wr_imm_i,
  input  logic              wr_tps_i,
  input  logic [WORD_W-1:0] cfg_data_i,
  output logic [TIME_W-1:0] time_now_o,
  output logic              pps_pulse_o,
  output logic              pending_o
);
  pps_edge_e         edge_q;
  pps_src_e          src_q;
  logic              imm_q;
  logic [WORD_W-1:0] tps_q;
  logic              commit;
  logic [WORD_W-1:0] stage_secs, stage_ticks, secs, ticks;
  logic [TIME_W-1:0] stage_time;
  logic [NUM_PPS_SRC-1:0] pps_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= EDGE_FALL;
      src_q  <= SRC_EXT;
      imm_q  <= 1'b0;
      tps_q  <= WORD_W'(RESET_TPS);
    end else begin
      if (wr_flags_i) begin
        edge_q <= pps_edge_e'(cfg_data_i[FLAG_EDGE_BIT]);
        src_q  <= pps_src_e'(cfg_data_i[FLAG_SRC_BIT]);
      end
      if (wr_imm_i) imm_q <= cfg_data_i[0];
      if (wr_tps_i) tps_q <= cfg_data_i;
    end
  end

  assign pps_vec[SRC_EXT]   = pps_ext_i;
  assign pps_vec[SRC_CABLE] = pps_cable_i;

  pps_edge_detect #(
    .NUM_SRC    (NUM_PPS_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pps_i  (pps_vec),
    .sel_i  (src_q),
    .rise_i (edge_q == EDGE_RISE),
    .pulse_o(pps_pulse_o)
  );

  time_load_stage #(.WORD_W(WORD_W)) u_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_secs_i    (wr_secs_i),
    .wr_ticks_i   (wr_ticks_i),
    .data_i       (cfg_data_i),
    .imm_i        (imm_q),
    .pps_pulse_i  (pps_pulse_o),
    .stage_secs_o (stage_secs),
    .stage_ticks_o(stage_ticks),
    .pending_o    (pending_o),
    .commit_o     (commit)
  );

  time_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (commit),
    .load_secs_i (stage_secs),
    .load_ticks_i(stage_ticks),
    .tps_i       (tps_q),
    .secs_o      (secs),
    .ticks_o     (ticks)
  );

  assign stage_time = {stage_secs, stage_ticks};
  assign time_now_o = {secs, ticks};
endmodule

// File: rtl/pps_time_base_chk.sv
module pps_time_base_chk #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_ticks_i,
  input logic              pending_o,
  input logic              pps_pulse_o,
  input logic [TIME_W-1:0] time_now_o,
  input logic              commit,
  input logic              imm_q,
  input logic [WORD_W-1:0] tps_q,
  input logic [TIME_W-1:0] stage_time
);
  logic [WORD_W-1:0] c_ticks, c_secs, c_last;
  assign c_ticks = time_now_o[WORD_W-1:0];
  assign c_secs  = time_now_o[TIME_W-1:WORD_W];
  assign c_last  = tps_q - 1'b1;

  AST_ARM_SETS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ticks_i |=> pending_o); // R4

  AST_PENDING_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !commit && !wr_ticks_i) |=> pending_o); // R4

  AST_IMM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && imm_q && !wr_ticks_i) |=> !pending_o); // R5

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (time_now_o == $past(stage_time))); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_pulse_o |=> !pps_pulse_o); // R7

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && (c_ticks < c_last)) |=>
      (c_ticks == $past(c_ticks) + 1'b1) && (c_secs == $past(c_secs))); // R2

  AST_TICK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && (c_ticks >= c_last)) |=>
      (c_ticks == '0) && (c_secs == $past(c_secs) + 1'b1)); // R2

  AST_IDLE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && pps_pulse_o) |=> (c_secs == $past(c_secs)) || (c_ticks == '0)); // R10
endmodule

bind pps_time_base pps_time_base_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_ticks_i (wr_ticks_i),
  .pending_o  (pending_o),
  .pps_pulse_o(pps_pulse_o),
  .time_now_o (time_now_o),
  .commit     (commit),
  .imm_q      (imm_q),
  .tps_q      (tps_q),
  .stage_time (stage_time)
);

// File: tb/pps_time_base_bench.sv
`timescale 1ns/1ps
module pps_time_base_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pps_ext = 1'b0, pps_cab = 1'b0;
  logic        wr_secs = 0, wr_ticks = 0, wr_flags = 0, wr_imm = 0, wr_tps = 0;
  logic [31:0] data = '0;
  logic [63:0] time_now;
  logic        pulse, pending;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pps_time_base u_pps_time_base (
    .clk_i(clk), .rst_ni(rst_ni), .pps_ext_i(pps_ext), .pps_cable_i(pps_cab),
    .wr_secs_i(wr_secs), .wr_ticks_i(wr_ticks), .wr_flags_i(wr_flags),
    .wr_imm_i(wr_imm), .wr_tps_i(wr_tps), .cfg_data_i(data),
    .time_now_o(time_now), .pps_pulse_o(pulse), .pending_o(pending)
  );

  // behavioural reference
  bit [2:0]    m_ext, m_cab;  // [0],[1] synchronizer, [2] previous
  bit [1:0]    m_flags;
  bit          m_imm, m_pend;
  bit [31:0]   m_tps, m_ss, m_st, m_secs, m_ticks;

  function automatic bit m_pulse();
    bit [2:0] h;
    h = m_flags[1] ? m_cab : m_ext;
    return m_flags[0] ? (h[1] && !h[2]) : (!h[1] && h[2]);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ext = 0; m_cab = 0; m_flags = 0; m_imm = 0; m_pend = 0;
      m_tps = 32'd250_000_000; m_ss = 0; m_st = 0; m_secs = 0; m_ticks = 0;
    end else begin
      bit cm;
      cm = m_pend && (m_imm || m_pulse());
      if (cm) begin m_secs = m_ss; m_ticks = m_st; end
      else if (m_ticks >= m_tps - 1) begin m_ticks = 0; m_secs = m_secs + 1; end
      else m_ticks = m_ticks + 1;
      m_ext = {m_ext[1:0], pps_ext};
      m_cab = {m_cab[1:0], pps_cab};
      if (wr_secs) m_ss = data;
      if (wr_ticks) begin m_st = data; m_pend = 1; end
      else if (cm) m_pend = 0;
      if (wr_flags) m_flags = data[1:0];
      if (wr_imm) m_imm = data[0];
      if (wr_tps) m_tps = data;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    chk("R2 model time", time_now, {m_secs, m_ticks});
    chk("R7 model pulse", {63'd0, pulse}, {63'd0, m_pulse()});
    chk("R4 model pending", {63'd0, pending}, {63'd0, m_pend});
  end

  // called at a negedge; returns at the next negedge
  task automatic wr(input int kind, input logic [31:0] d);
    data = d;
    case (kind)
      0: wr_secs = 1; 1: wr_ticks = 1; 2: wr_flags = 1; 3: wr_imm = 1; default: wr_tps = 1;
    endcase
    @(negedge clk);
    {wr_secs, wr_ticks, wr_flags, wr_imm, wr_tps} = '0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] s0, t0;
    tick(3);
    chk("R1 reset time", time_now, 64'd0);
    chk("R1 reset pending", {63'd0, pending}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 first tick", time_now, 64'd1);

    // R2: rollover at 10 ticks per second
    wr(4, 32'd10);
    for (int i = 0; i < 40 && time_now[31:0] != 32'd9; i++) @(negedge clk);
    s0 = time_now[63:32];
    @(negedge clk);
    chk("R2 wrap", time_now, {s0 + 32'd1, 32'd0});

    // R3: seconds staging alone does not arm or load
    wr(0, 32'h55);
    tick(3);
    chk("R3 no arm", {63'd0, pending}, 64'd0);
    chk("R3 no load", {63'd0, time_now[63:32] == 32'h55}, 64'd0);

    // R5 immediate load
    wr(3, 32'd1);
    wr(0, 32'd100);
    wr(1, 32'd3);
    chk("R4 armed", {63'd0, pending}, 64'd1);
    @(negedge clk);
    chk("R5 immediate load", time_now, {32'd100, 32'd3});
    chk("R5 pending clear", {63'd0, pending}, 64'd0);

    // R9: commit lands on a wrap cycle
    wr(0, 32'd200);
    for (int i = 0; i < 40 && time_now[31:0] != 32'd8; i++) @(negedge clk);
    wr(1, 32'd5);
    chk("R9 pre-commit tick", {32'd0, time_now[31:0]}, 64'd9);
    @(negedge clk);
    chk("R9 commit beats wrap", time_now, {32'd200, 32'd5});

    // R11: re-arm in commit cycle
    wr(1, 32'd1);
    wr(1, 32'd7);
    chk("R11 old ticks loaded", time_now, {32'd200, 32'd1});
    chk("R11 still pending", {63'd0, pending}, 64'd1);
    @(negedge clk);
    chk("R11 new ticks loaded", time_now, {32'd200, 32'd7});

    // R6 PPS mode, rising edge, external source
    wr(3, 32'd0);
    wr(2, 32'd1);
    wr(0, 32'd300);
    wr(1, 32'd0);
    tick(5);
    chk("R6 waits for pps", {63'd0, pending}, 64'd1);
    pps_cab = 1'b1;
    tick(5);
    chk("R8 other source ignored", {63'd0, pending}, 64'd1);
    pps_ext = 1'b1;
    @(negedge clk);
    chk("R7 no pulse after one edge", {63'd0, pulse}, 64'd0);
    @(negedge clk);
    chk("R7 pulse after two edges", {63'd0, pulse}, 64'd1);
    @(negedge clk);
    chk("R6 pps load", time_now, {32'd300, 32'd0});
    chk("R6 pending clear", {63'd0, pending}, 64'd0);
    chk("R7 pulse one clock", {63'd0, pulse}, 64'd0);

    // R10: pulse with nothing pending
    pps_ext = 1'b0;
    tick(4);
    pps_ext = 1'b1;
    tick(2);
    chk("R10 pulse seen", {63'd0, pulse}, 64'd1);
    s0 = time_now[63:32]; t0 = time_now[31:0];
    @(negedge clk);
    if (t0 >= 32'd9) chk("R10 keeps counting", time_now, {s0 + 32'd1, 32'd0});
    else             chk("R10 keeps counting", time_now, {s0, t0 + 32'd1});

    // R7/R8: falling edge on the cable input
    wr(2, 32'd2);
    wr(0, 32'd400);
    wr(1, 32'd2);
    pps_ext = 1'b0;
    tick(4);
    chk("R8 ext edge ignored", {63'd0, pending}, 64'd1);
    pps_cab = 1'b0;
    tick(2);
    chk("R7 falling pulse", {63'd0, pulse}, 64'd1);
    @(negedge clk);
    chk("R8 cable load", time_now, {32'd400, 32'd2});
    tick(3);
    finish_run();
  end
endmodule